// File: doc/BRIEF.md
# Dual-Chain Bus Mastership Arbiter

This block decides who owns the shared buses of a chip with four internal bus masters: a CPU, a data-transfer controller, a general DMA controller and a DMA engine dedicated to the external bus. Each master has its own request line and receives its own acknowledge line. An internal chain picks one internal owner at each internal bus-cycle boundary. The CPU is the default owner when nobody asks.

A second, independent chain arbitrates the external bus. It decides among four kinds of work. The first is a DRAM refresh. The second is an external access by the external-bus DMA engine. The third is a bus-release request from an outside device, which arrives asynchronously and is synchronized inside the block. The fourth is an external access started by whichever internal master currently holds the internal bus. Because the two chains are separate, internal traffic continues while the external bus is refreshed, released or used by the external-bus DMA engine.

A single mode input decides whether refresh may share the external bus with non-DRAM external accesses. When the input is low, the two may run together and neither has priority over the other. When it is high, refresh has the external bus to itself: it waits for any external access already running and blocks new ones until it has finished.

Top module: `bus_master_arbiter`

## Requirements
- R1: While reset is held, `mst_ack` is 4'b0001 (the CPU, bit 0) and every external acknowledge is low.
- R2: Exactly one bit of `mst_ack` is high in every clock cycle.
- R3: On a clock edge with `int_cyc_end` high, `mst_ack` is loaded with the highest requesting master. Bit 3 (external-bus DMA) ranks above bit 2 (general DMA), bit 2 above bit 1 (data-transfer controller), and bit 1 above bit 0 (CPU). With no request, the CPU (bit 0) is selected.
- R4: On an edge with `int_cyc_end` low, `mst_ack` keeps its value whatever the requests do, so a running cycle is never pre-empted.
- R5: When refresh, external-bus DMA, bus-release and internal external-access requests arrive together on an idle external bus, refresh is acknowledged first.
- R6: The external-bus DMA access ranks above the bus release and above internal external accesses, and it never overlaps an internal external access or a refresh.
- R7: A bus-release request ranks above an external access by an internal master.
- R8: `brel_ack` rises on the third clock edge after `brel_req_in` rises on an idle bus. It stays high until the request has been low through the two synchronizer stages, and then falls on the third edge after the request falls.
- R9: With `ref_excl_mode` low, a refresh is granted while a non-DRAM internal external access (`iext_dram` low) is running, and both acknowledges are high together.
- R10: With `ref_excl_mode` high, or when the running internal external access targets DRAM, refresh waits for that access to end. While refresh runs in exclusive mode, no new internal external access is granted.
- R11: `refresh_ack` stays high until `refresh_done`. `xdma_ext_ack` and `iext_ack` stay high until `ext_cyc_end`.
- R12: While `brel_ack` is high, no other external acknowledge is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_req | input | 4 | Internal bus requests: bit 0 CPU, 1 data-transfer ctrl, 2 general DMA, 3 external-bus DMA |
| int_cyc_end | input | 1 | Internal bus-cycle boundary strobe |
| mst_ack | output | 4 | Registered one-hot internal bus acknowledge |
| refresh_req | input | 1 | DRAM refresh request |
| refresh_done | input | 1 | Refresh operation finished |
| refresh_ack | output | 1 | Refresh owns the external bus |
| xdma_ext_req | input | 1 | External access request from the external-bus DMA |
| xdma_ext_ack | output | 1 | External-bus DMA access granted |
| brel_req_in | input | 1 | Asynchronous bus-release request from an outside device |
| brel_ack | output | 1 | External bus released to the outside device |
| iext_req | input | 1 | External access request by the current internal owner |
| iext_dram | input | 1 | That access targets DRAM space |
| iext_ack | output | 1 | Internal master's external access granted |
| ext_cyc_end | input | 1 | End of the running external access cycle |
| ref_excl_mode | input | 1 | 1: refresh is exclusive; 0: refresh may overlap non-DRAM accesses |

## Verification
The assertions assume that `ref_excl_mode` changes only while no external acknowledge is high. They also assume that `refresh_done` is pulsed only while refresh is acknowledged and that `ext_cyc_end` is pulsed only while a DMA or internal external access is acknowledged. The stimulus respects these limits by changing the mode only between scenarios, after every grant has been retired, and by pulsing each end strobe for one cycle only while its own grant is visible. The internal chain is swept over all sixteen request patterns, and each pattern is followed by a request change without a boundary strobe.

// File: rtl/arb_pkg.sv
// Package: shared constants and types for the bus mastership arbiter.
// Assumes master indices rise with priority (higher index wins).
package arb_pkg;
    localparam int NUM_MST   = 4;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        M_CPU  = 2'd0,
        M_DTC  = 2'd1,
        M_DMA  = 2'd2,
        M_XDMA = 2'd3
    } mst_e;

    // External-side grant vector, one bit per external operation kind.
    typedef struct packed {
        logic refr;
        logic xdma;
        logic brel;
        logic iext;
    } ext_grant_t;
endpackage

// File: rtl/arb_sync.sv
// Module: multi-stage synchronizer for an asynchronous level input.
// Assumes the input is a slowly changing level; the output lags by STAGES edges.
module arb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Shift the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/arb_int_chain.sv
// Module: fixed-priority internal bus chain.
// Picks the highest-index requester at each cycle-end strobe, parks on
// DEF_IDX when idle, and otherwise holds the present owner.
// Assumes the strobe marks the boundary of the current internal cycle.
module arb_int_chain #(
    parameter int N       = 4,
    parameter int DEF_IDX = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         cyc_end,
    output logic [N-1:0] ack
);
    localparam logic [N-1:0] DEF_VEC = N'(1) << DEF_IDX;

    logic [N-1:0] winner;
    logic [N-1:0] ack_q;

    // Priority encode: ascending scan so the highest index wins.
    always_comb begin
        winner = DEF_VEC;
        for (int i = 0; i < N; i++) begin
            if (req[i]) winner = N'(1) << i;
        end
    end

    // Load the winner only at a boundary; hold the owner between boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_q <= DEF_VEC;
        else if (cyc_end) ack_q <= winner;
    end

    assign ack = ack_q;
endmodule

// File: rtl/arb_ext_chain.sv
// Module: external bus chain with refresh overlap rules.
// Order: refresh > external-bus DMA > bus release > internal external access.
// Each grant is held until its own end condition; the freed resources are
// re-arbitrated in the same clock. With excl_mode low, refresh may overlap
// a non-DRAM internal access; otherwise all external operations are exclusive.
// Assumes excl_mode is static while any grant is active.
module arb_ext_chain (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_req,
    input  logic                ref_done,
    input  logic                xd_req,
    input  logic                br_req,
    input  logic                ie_req,
    input  logic                ie_dram,
    input  logic                cyc_end,
    input  logic                excl_mode,
    output arb_pkg::ext_grant_t grant
);
    import arb_pkg::*;

    ext_grant_t g_q;
    ext_grant_t g_d;
    logic       ie_dram_q;

    logic hold_ref, hold_xd, hold_ie, hold_br;
    logic new_ref, new_xd, new_br, new_ie;
    logic any_ref, ie_fits_ref, ref_fits_ie;

    // Work out which operations survive this clock.
    always_comb begin
        hold_ref = g_q.refr & ~ref_done;
        hold_xd  = g_q.xdma & ~cyc_end;
        hold_ie  = g_q.iext & ~cyc_end;
        hold_br  = g_q.brel &  br_req;
    end

    // Refresh may join a running internal access only if it is non-DRAM and shared mode.
    always_comb begin
        ref_fits_ie = ~hold_ie | (~excl_mode & ~ie_dram_q);
        new_ref     = ref_req & ~hold_ref & ~hold_xd & ~hold_br & ref_fits_ie;
        any_ref     = hold_ref | new_ref;
    end

    // Lower-ranked grants in strict order behind refresh.
    always_comb begin
        new_xd      = xd_req & ~hold_xd & ~hold_ie & ~hold_br & ~any_ref;
        new_br      = br_req & ~hold_br & ~hold_xd & ~hold_ie & ~any_ref & ~new_xd;
        ie_fits_ref = ~any_ref | (~excl_mode & ~ie_dram);
        new_ie      = ie_req & ~hold_ie & ~hold_xd & ~hold_br
                    & ~new_xd & ~new_br & ie_fits_ref;
    end

    // Assemble the next grant vector.
    always_comb begin
        g_d.refr = any_ref;
        g_d.xdma = hold_xd | new_xd;
        g_d.brel = hold_br | new_br;
        g_d.iext = hold_ie | new_ie;
    end

    // Register grants and the target space of the granted internal access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q       <= '0;
            ie_dram_q <= 1'b0;
        end else begin
            g_q <= g_d;
            if (new_ie) ie_dram_q <= ie_dram;
        end
    end

    assign grant = g_q;
endmodule

// File: rtl/bus_master_arbiter.sv
// Module: top of the bus mastership arbiter.
// Runs the internal and external chains side by side and synchronizes the
// outside bus-release request. Assumes a single clock domain apart from
// brel_req_in.
module bus_master_arbiter #(
    parameter int NUM_MST    = arb_pkg::NUM_MST,
    parameter int SYNC_DEPTH = arb_pkg::SYNC_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] mst_req,
    input  logic               int_cyc_end,
    output logic [NUM_MST-1:0] mst_ack,
    input  logic               refresh_req,
    input  logic               refresh_done,
    output logic               refresh_ack,
    input  logic               xdma_ext_req,
    output logic               xdma_ext_ack,
    input  logic               brel_req_in,
    output logic               brel_ack,
    input  logic               iext_req,
    input  logic               iext_dram,
    output logic               iext_ack,
    input  logic               ext_cyc_end,
    input  logic               ref_excl_mode
);
    import arb_pkg::*;

    logic       brel_sync;
    ext_grant_t ext_g;

    arb_sync #(.STAGES(SYNC_DEPTH)) u_brel_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (brel_req_in),
        .q_sync  (brel_sync)
    );

    arb_int_chain #(.N(NUM_MST), .DEF_IDX(int'(M_CPU))) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (mst_req),
        .cyc_end (int_cyc_end),
        .ack     (mst_ack)
    );

    arb_ext_chain u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_req   (refresh_req),
        .ref_done  (refresh_done),
        .xd_req    (xdma_ext_req),
        .br_req    (brel_sync),
        .ie_req    (iext_req),
        .ie_dram   (iext_dram),
        .cyc_end   (ext_cyc_end),
        .excl_mode (ref_excl_mode),
        .grant     (ext_g)
    );

    assign refresh_ack  = ext_g.refr;
    assign xdma_ext_ack = ext_g.xdma;
    assign brel_ack     = ext_g.brel;
    assign iext_ack     = ext_g.iext;
endmodule

// File: rtl/arb_checker.sv
// Module: property checker for bus_master_arbiter, attached by bind.
// Assumes mode is static while grants are active and end strobes match grants.
module arb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mst_req,
    input logic       int_cyc_end,
    input logic [3:0] mst_ack,
    input logic       refresh_ack,
    input logic       refresh_done,
    input logic       xdma_ext_ack,
    input logic       brel_ack,
    input logic       iext_ack,
    input logic       ext_cyc_end,
    input logic       ref_excl_mode
);
    p_cpu_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mst_ack == 4'b0001) && !refresh_ack && !xdma_ext_ack
                         && !brel_ack && !iext_ack);

    p_single_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mst_ack) == 1);

    p_top_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cyc_end && mst_req[3]) |=> mst_ack[3]);

    p_idle_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_cyc_end && mst_req == 4'b0000) |=> mst_ack == 4'b0001);

    p_no_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_cyc_end |=> $stable(mst_ack));

    p_ref_xd_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(refresh_ack && xdma_ext_ack));

    p_xd_ie_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(xdma_ext_ack && iext_ack));

    p_excl_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_ack && iext_ack) |-> !ref_excl_mode);

    p_ref_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_ack && !refresh_done) |=> refresh_ack);

    p_ie_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iext_ack && !ext_cyc_end) |=> iext_ack);

    p_brel_alone_r12: assert property (@(posedge clk) disable iff (!rst_n)
        brel_ack |-> !(refresh_ack || xdma_ext_ack || iext_ack));
endmodule

bind bus_master_arbiter arb_checker u_arb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mst_req       (mst_req),
    .int_cyc_end   (int_cyc_end),
    .mst_ack       (mst_ack),
    .refresh_ack   (refresh_ack),
    .refresh_done  (refresh_done),
    .xdma_ext_ack  (xdma_ext_ack),
    .brel_ack      (brel_ack),
    .iext_ack      (iext_ack),
    .ext_cyc_end   (ext_cyc_end),
    .ref_excl_mode (ref_excl_mode)
);

// File: tb/test_bus_master_arbiter.sv
// Bench: sweeps the internal chain and walks the external ordering scenarios.
module test_bus_master_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mst_req = '0;
    logic       int_cyc_end = 1'b0;
    logic [3:0] mst_ack;
    logic       refresh_req = 1'b0, refresh_done = 1'b0, refresh_ack;
    logic       xdma_ext_req = 1'b0, xdma_ext_ack;
    logic       brel_req_in = 1'b0, brel_ack;
    logic       iext_req = 1'b0, iext_dram = 1'b0, iext_ack;
    logic       ext_cyc_end = 1'b0, ref_excl_mode = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bus_master_arbiter i_bus_master_arbiter (
        .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .int_cyc_end(int_cyc_end),
        .mst_ack(mst_ack), .refresh_req(refresh_req), .refresh_done(refresh_done),
        .refresh_ack(refresh_ack), .xdma_ext_req(xdma_ext_req),
        .xdma_ext_ack(xdma_ext_ack), .brel_req_in(brel_req_in), .brel_ack(brel_ack),
        .iext_req(iext_req), .iext_dram(iext_dram), .iext_ack(iext_ack),
        .ext_cyc_end(ext_cyc_end), .ref_excl_mode(ref_excl_mode)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // External acks packed as {ref, xd, brel, iext}.
    function automatic logic [3:0] ext_v();
        return {refresh_ack, xdma_ext_ack, brel_ack, iext_ack};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_ack;
        #1;
        step(); step(); step();
        chk("R1 reset mst_ack", 32'(mst_ack), 32'h1);
        chk("R1 reset ext acks", 32'(ext_v()), 32'h0);
        rst_n = 1'b1;

        // Internal chain: all sixteen request patterns.
        for (int p = 0; p < 16; p++) begin
            exp_ack = 4'b0001;
            for (int b = 0; b < 4; b++) if (p[b]) exp_ack = 4'(1 << b);
            mst_req = 4'(p);
            int_cyc_end = 1'b1;
            step();
            int_cyc_end = 1'b0;
            chk($sformatf("R3 pick p=%0d", p), 32'(mst_ack), 32'(exp_ack));
            chk("R2 one-hot", 32'($countones(mst_ack)), 32'd1);
            mst_req = ~4'(p);
            step();
            chk($sformatf("R4 hold p=%0d", p), 32'(mst_ack), 32'(exp_ack));
        end
        mst_req = '0;

        // R8 rise latency on an idle bus.
        brel_req_in = 1'b1;
        step(); chk("R8 edge1", 32'(brel_ack), 32'd0);
        step(); chk("R8 edge2", 32'(brel_ack), 32'd0);
        step(); chk("R8 edge3 rise", 32'(brel_ack), 32'd1);
        brel_req_in = 1'b0;
        step(); step(); step();
        chk("R8 fall idle", 32'(brel_ack), 32'd0);

        // Everything at once, exclusive mode.
        ref_excl_mode = 1'b1;
        brel_req_in = 1'b1; xdma_ext_req = 1'b1; iext_req = 1'b1; refresh_req = 1'b1;
        step();
        chk("R5 refresh first", 32'(ext_v()), 32'b1000);
        step(); step();
        chk("R11 refresh held", 32'(ext_v()), 32'b1000);
        refresh_done = 1'b1; refresh_req = 1'b0;
        step();
        refresh_done = 1'b0;
        chk("R6 xdma next", 32'(ext_v()), 32'b0100);
        step();
        chk("R11 xdma held", 32'(ext_v()), 32'b0100);
        ext_cyc_end = 1'b1; xdma_ext_req = 1'b0;
        step();
        ext_cyc_end = 1'b0;
        chk("R7 release over iext", 32'(ext_v()), 32'b0010);
        chk("R12 release alone", 32'(ext_v() & 4'b1101), 32'h0);
        brel_req_in = 1'b0;
        step(); chk("R8 held edge1", 32'(brel_ack), 32'd1);
        step(); chk("R8 held edge2", 32'(brel_ack), 32'd1);
        step(); chk("R8 fall then iext", 32'(ext_v()), 32'b0001);
        ext_cyc_end = 1'b1; iext_req = 1'b0;
        step();
        ext_cyc_end = 1'b0;

        // Shared mode, non-DRAM access overlapped by refresh.
        ref_excl_mode = 1'b0;
        iext_req = 1'b1; iext_dram = 1'b0;
        step();
        chk("R9 iext granted", 32'(ext_v()), 32'b0001);
        refresh_req = 1'b1;
        step();
        chk("R9 overlap", 32'(ext_v()), 32'b1001);
        refresh_done = 1'b1; refresh_req = 1'b0; ext_cyc_end = 1'b1; iext_req = 1'b0;
        step();
        refresh_done = 1'b0; ext_cyc_end = 1'b0;
        chk("R11 both retired", 32'(ext_v()), 32'b0000);

        // Exclusive mode: refresh waits, then blocks new accesses.
        ref_excl_mode = 1'b1;
        iext_req = 1'b1;
        step();
        refresh_req = 1'b1;
        step();
        chk("R10 refresh waits", 32'(ext_v()), 32'b0001);
        step();
        chk("R10 still waits", 32'(ext_v()), 32'b0001);
        ext_cyc_end = 1'b1;
        step();
        ext_cyc_end = 1'b0;
        chk("R10 refresh takes bus", 32'(ext_v()), 32'b1000);
        step();
        chk("R10 iext blocked", 32'(ext_v()), 32'b1000);
        refresh_done = 1'b1; refresh_req = 1'b0;
        step();
        refresh_done = 1'b0;
        chk("R10 iext after refresh", 32'(ext_v()), 32'b0001);
        ext_cyc_end = 1'b1; iext_req = 1'b0;
        step();
        ext_cyc_end = 1'b0;

        // Shared mode, DRAM target: no overlap.
        ref_excl_mode = 1'b0;
        iext_req = 1'b1; iext_dram = 1'b1;
        step();
        refresh_req = 1'b1;
        step();
        chk("R10 DRAM no overlap", 32'(ext_v()), 32'b0001);
        ext_cyc_end = 1'b1; iext_req = 1'b0;
        step();
        ext_cyc_end = 1'b0;
        chk("R10 DRAM then refresh", 32'(ext_v()), 32'b1000);
        refresh_done = 1'b1; refresh_req = 1'b0;
        step();
        refresh_done = 1'b0;
        chk("R2 one-hot at end", 32'($countones(mst_ack)), 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule